// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Frame Transmitter

This block puts a frame of bytes onto a single-wire bus. The bus carries information in the length of each level between transitions. Every bit is one timed level, and consecutive bits take opposite levels. So the length of a bit depends on its logic value and on the level it is forced to take. The block drives one active/passive output. It watches the wired bus level, holds off until the line has been quiet for longer than the inter-frame gap, then sends an active start symbol. After that it sends each byte most significant bit first, and finally releases the line and times the closing quiet period. All timing is counted in microsecond ticks, which arrive as a one-cycle enable.

Bytes enter through a valid/ready stream with a last-byte flag. The block raises `in_ready` for one phase only: the passive window that opens each byte. In that window the first bit of the byte is already being timed. A presented byte is taken at the first clock edge of the window. `in_ready` is low in idle, during the start symbol, during bit serialization and during the closing period. A frame starts only while `in_valid` is high, and that first byte is consumed after the start symbol ends. The source keeps the next byte valid while earlier ones are sent. If it is late, the opening passive bit is stretched until the byte arrives. The bit then ends on the first tick after the load on which its nominal length has already passed.

Top module: `vpw_tx`

## Requirements
- R1: While reset is asserted (synchronous, active high), the output goes passive (`tx_active` = 0) and `in_ready` and `done` go low.
- R2: A frame starts only on a tick edge where `in_valid` is high, the bus input is passive, and the bus has already been passive for at least IFS_US+1 consecutive ticks (default 300). Any active bus sample restarts that count. With a tick every cycle, the first active output cycle comes IFS_US+2 clock edges after the bus is first seen passive.
- R3: A frame opens with an active start symbol that lasts SOF_US ticks (default 200).
- R4: Each bit is exactly one level. The first bit of every byte is passive (`tx_active` = 0), and the levels alternate from bit to bit.
- R5: Bit lengths in ticks: a 0 is SHORT_US when passive and LONG_US when active; a 1 is LONG_US when passive and SHORT_US when active (defaults 64 and 128).
- R6: The bits of each byte are sent in order from bit 7 down to bit 0, and the bytes are sent in the order they were accepted.
- R7: `in_ready` is high only while the output is passive and a byte is awaited. A valid byte is taken in one handshake, so with `in_valid` held high `in_ready` is high for exactly one cycle per byte.
- R8: After the final bit of the byte marked last, the output is released to passive and stays there. `done` pulses high for one cycle, EOF_US ticks after the release (default 280).
- R9: Time advances only on cycles where `tick_us` is high. With no tick the output never changes, and with a tick every N cycles every duration is N times as many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_us | input | 1 | One-cycle microsecond time enable |
| bus_active_i | input | 1 | Sensed bus level, 1 = active (includes own drive) |
| in_data | input | BYTE_W | Byte to send |
| in_last | input | 1 | Marks the final byte of the frame |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| tx_active | output | 1 | Bus drive, 1 = active level |
| done | output | 1 | One-cycle pulse at the end of the closing period |

## Verification
The byte handshake that opens a byte can fall on the same edge as a tick. Then that edge both loads the byte and counts the first unit of the byte's opening passive bit. The bench provokes this in two ways: with a tick every cycle, where the two always coincide, and with a tick every third cycle, where they may or may not. It judges each case by measuring every run of the output level in cycles and comparing it with the tick count multiplied by the tick spacing. The start decision, in turn, meets the release of the bus by another node. This is judged by counting the clock edges between that release and the first active cycle.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_FETCH,
    ST_BITS,
    ST_EOF
  } vpw_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/vpw_idle_detect.sv
module vpw_idle_detect #(
  parameter int unsigned IFS_US = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic bus_active_i,
  output logic bus_idle
);
  localparam int unsigned W = $clog2(IFS_US + 2);
  localparam logic [W-1:0] TOP = W'(IFS_US + 1);

  logic [W-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || bus_active_i) begin
      quiet_cnt <= '0;
    end else if (tick_us && quiet_cnt != TOP) begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  assign bus_idle = (quiet_cnt == TOP);
endmodule

// File: rtl/vpw_symbol_len.sv
module vpw_symbol_len #(
  parameter int unsigned SHORT_US = 64,
  parameter int unsigned LONG_US  = 128,
  parameter int unsigned W        = 8
) (
  input  logic         data_bit,
  input  logic         level,
  output logic [W-1:0] len
);
  // A bit whose value differs from its level is the long one.
  assign len = (data_bit ^ level) ? W'(LONG_US) : W'(SHORT_US);
endmodule

// File: rtl/vpw_byte_shifter.sv
module vpw_byte_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  input  logic              last_in,
  output logic              msb,
  output logic              final_bit,
  output logic              last_q
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      idx    <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      shreg  <= din;
      idx    <= '0;
      last_q <= last_in;
    end else if (shift) begin
      shreg  <= {shreg[BYTE_W-2:0], 1'b0};
      idx    <= idx + 1'b1;
    end
  end

  assign msb       = shreg[BYTE_W-1];
  assign final_bit = (idx == IDX_LAST);
endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
  import vpw_tx_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned SHORT_US = 64,
  parameter int unsigned LONG_US  = 128,
  parameter int unsigned SOF_US   = 200,
  parameter int unsigned EOF_US   = 280,
  parameter int unsigned IFS_US   = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              bus_active_i,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_active,
  output logic              done
);
  localparam int unsigned MAX_US = max3(SOF_US, EOF_US, LONG_US);
  localparam int unsigned CNT_W  = $clog2(MAX_US + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] SOF_END = CNT_W'(SOF_US - 1);
  localparam logic [CNT_W-1:0] EOF_END = CNT_W'(EOF_US - 1);

  vpw_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             tx_q;
  logic             done_q;
  logic             bus_idle;
  logic             cur_bit;
  logic             final_bit;
  logic             frame_last;
  logic [CNT_W-1:0] bit_len;
  logic             load_byte;
  logic             bit_end;
  logic             shift_byte;
  logic             start_ok;

  vpw_idle_detect #(.IFS_US(IFS_US)) u_idle (
    .clk          (clk),
    .rst          (rst),
    .tick_us      (tick_us),
    .bus_active_i (bus_active_i),
    .bus_idle     (bus_idle)
  );

  vpw_symbol_len #(.SHORT_US(SHORT_US), .LONG_US(LONG_US), .W(CNT_W)) u_len (
    .data_bit (cur_bit),
    .level    (tx_q),
    .len      (bit_len)
  );

  vpw_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load_byte),
    .shift     (shift_byte),
    .din       (in_data),
    .last_in   (in_last),
    .msb       (cur_bit),
    .final_bit (final_bit),
    .last_q    (frame_last)
  );

  assign in_ready   = (state == ST_FETCH);
  assign load_byte  = in_ready && in_valid;
  assign bit_end    = (state == ST_BITS) && tick_us && (cnt >= bit_len - 1'b1);
  assign shift_byte = bit_end && !final_bit;
  assign start_ok   = (state == ST_IDLE) && in_valid && bus_idle && !bus_active_i && tick_us;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      tx_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state <= ST_SOF;
            tx_q  <= 1'b1;
            cnt   <= '0;
          end
        end
        ST_SOF: begin
          if (tick_us) begin
            if (cnt == SOF_END) begin
              state <= ST_FETCH;
              tx_q  <= 1'b0;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_FETCH: begin
          // Opening passive bit is already being timed here.
          if (tick_us && cnt != CNT_SAT) cnt <= cnt + 1'b1;
          if (in_valid) state <= ST_BITS;
        end
        ST_BITS: begin
          if (bit_end) begin
            cnt <= '0;
            if (final_bit) begin
              tx_q  <= 1'b0;
              state <= frame_last ? ST_EOF : ST_FETCH;
            end else begin
              tx_q <= ~tx_q;
            end
          end else if (tick_us) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EOF: begin
          if (tick_us) begin
            if (cnt == EOF_END) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              cnt    <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_active = tx_q;
  assign done      = done_q;
endmodule

// File: rtl/vpw_tx_chk.sv
module vpw_tx_chk (
  input logic clk,
  input logic rst,
  input logic tick_us,
  input logic in_ready,
  input logic tx_active,
  input logic done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!tx_active && !in_ready && !done));

  a_r7_ready_only_passive: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !tx_active);

  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_release: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tx_active && !$past(tx_active)));

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_us |=> $stable(tx_active));
endmodule

bind vpw_tx vpw_tx_chk u_vpw_tx_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_us   (tick_us),
  .in_ready  (in_ready),
  .tx_active (tx_active),
  .done      (done)
);

// File: tb/tb_vpw_tx.sv
module tb_vpw_tx;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 2;
  localparam int LONG  = 4;
  localparam int SOF   = 5;
  localparam int EOFT  = 3;
  localparam int IFS   = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_us = 1'b0;
  logic       other_act = 1'b0;
  logic       bus_active_i;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       tx_active;
  logic       done;

  int tests = 0;
  int fails = 0;

  int tick_div = 1;
  int tick_phase = 0;
  bit tick_on = 1'b1;

  logic [7:0] frame_b [256];
  bit    exp_lvl [$];
  int    exp_len [$];
  int    exp_kind [$];
  string exp_tag [$];

  bit   started = 1'b0;
  bit   prev_lvl = 1'b0;
  int   run = 0;
  int   low_run = 0;
  int   last_gap = 0;
  int   ready_seen = 0;
  bit   frame_done = 1'b0;
  logic [7:0] dec_acc = '0;
  int   dec_n = 0;
  int   dec_idx = 0;

  assign bus_active_i = tx_active | other_act;

  vpw_tx #(
    .BYTE_W(8), .SHORT_US(SHORT), .LONG_US(LONG),
    .SOF_US(SOF), .EOF_US(EOFT), .IFS_US(IFS)
  ) dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .bus_active_i(bus_active_i),
    .in_data(in_data), .in_last(in_last), .in_valid(in_valid),
    .in_ready(in_ready), .tx_active(tx_active), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!tick_on) begin
      tick_us = 1'b0;
    end else begin
      tick_us = (tick_phase == 0);
      tick_phase = (tick_phase + 1 >= tick_div) ? 0 : tick_phase + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic pop_check(input bit lvl, input int len);
    bit el; int ek; int en; string et; bit dbit;
    if (exp_len.size() == 0) begin
      chk(1'b0, "R8", len, -1);
      return;
    end
    el = exp_lvl.pop_front();
    en = exp_len.pop_front();
    ek = exp_kind.pop_front();
    et = exp_tag.pop_front();
    chk(el == lvl && en == len, et, {lvl, len[30:0]} , {el, en[30:0]});
    if (ek == 1) begin
      dbit = lvl ? (len == SHORT * tick_div) : (len == LONG * tick_div);
      dec_acc = {dec_acc[6:0], dbit};
      dec_n++;
      if (dec_n == 8) begin
        chk(dec_acc == frame_b[dec_idx], "R6", dec_acc, frame_b[dec_idx]);
        dec_idx++;
        dec_n = 0;
      end
    end
  endtask

  // Output monitor: measures every level run in cycles.
  always @(negedge clk) begin
    if (rst) begin
      started = 1'b0;
    end else if (!started) begin
      if (done) chk(1'b0, "R8", 1, 0);
      if (tx_active) begin
        started = 1'b1;
        prev_lvl = 1'b1;
        run = 1;
        ready_seen = 0;
        last_gap = low_run;
      end else begin
        low_run++;
      end
    end else begin
      if (in_ready) ready_seen++;
      if (done) begin
        pop_check(1'b0, run);
        started = 1'b0;
        frame_done = 1'b1;
        low_run = run + 1;
      end else if (tx_active != prev_lvl) begin
        pop_check(prev_lvl, run);
        prev_lvl = tx_active;
        run = 1;
      end else begin
        run++;
      end
    end
  end

  task automatic run_frame(input int n, input int div);
    bit lvl;
    int len;
    tick_div = div;
    tick_phase = 0;
    exp_lvl.delete(); exp_len.delete(); exp_kind.delete(); exp_tag.delete();
    exp_lvl.push_back(1'b1); exp_len.push_back(SOF * div);
    exp_kind.push_back(0); exp_tag.push_back("R3");
    for (int i = 0; i < n; i++) begin
      lvl = 1'b0;
      for (int k = 7; k >= 0; k--) begin
        len = (frame_b[i][k] ^ lvl) ? LONG : SHORT;
        exp_lvl.push_back(lvl); exp_len.push_back(len * div);
        exp_kind.push_back(1); exp_tag.push_back("R4 R5");
        lvl = !lvl;
      end
    end
    exp_lvl.push_back(1'b0); exp_len.push_back(EOFT * div);
    exp_kind.push_back(2); exp_tag.push_back("R8");
    dec_n = 0; dec_idx = 0; frame_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_data = frame_b[i];
      in_last = (i == n - 1);
      in_valid = 1'b1;
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    wait (frame_done);
    @(negedge clk);
    chk(ready_seen == n, "R7", ready_seen, n);
    chk(exp_len.size() == 0, "R8", exp_len.size(), 0);
    chk(dec_idx == n, "R6", dec_idx, n);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit bad;
    int k;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!tx_active, "R1", tx_active, 0);
    chk(!in_ready, "R1", in_ready, 0);
    chk(!done, "R1", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_active && !in_ready && !done, "R1", {tx_active, in_ready, done}, 0);

    // R9: no tick means no start, no handshake
    tick_on = 1'b0;
    in_data = 8'h11; in_last = 1'b1; in_valid = 1'b1;
    bad = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (tx_active || in_ready) bad = 1'b1;
    end
    chk(!bad, "R9", bad, 0);
    in_valid = 1'b0; in_last = 1'b0;
    tick_on = 1'b1;

    // R2: hold-off while another node drives, then exact start delay
    other_act = 1'b1;
    frame_b[0] = 8'h5A;
    fork
      run_frame(1, 1);
      begin
        bad = 1'b0;
        repeat (20) begin
          @(negedge clk);
          if (tx_active) bad = 1'b1;
        end
        chk(!bad, "R2", bad, 0);
        @(negedge clk);
        other_act = 1'b0;
        k = 0;
        do begin
          @(posedge clk);
          #1;
          k++;
        end while (!tx_active && k < 100);
        chk(k == IFS + 2, "R2", k, IFS + 2);
      end
    join

    // R4 R5 R6 R7 R8: every byte value in one frame
    for (int i = 0; i < 256; i++) frame_b[i] = 8'(i);
    run_frame(256, 1);

    // R2: back-to-back frames keep the inter-frame gap
    frame_b[0] = 8'h81;
    run_frame(1, 1);
    run_frame(1, 1);
    chk(last_gap == IFS + 2, "R2", last_gap, IFS + 2);

    // R9: tick every third cycle scales every duration
    frame_b[0] = 8'hA5; frame_b[1] = 8'h00; frame_b[2] = 8'hFF; frame_b[3] = 8'h3C;
    run_frame(4, 3);
    tick_div = 1;
    tick_phase = 0;

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule